// File: doc/BRIEF.md
# FSK Zero-Crossing Frame Demodulator

This block recovers frames from a low-frequency tag that answers by switching its carrier between two frequencies. Its input is a single-bit zero-crossing signal, sampled once per `smp_vld` strobe at a nominal 2 MHz rate. The block counts carrier cycles on rising edges. After every group of 16 cycles it takes the number of samples the group spanned and turns that count into a data bit, or rejects it.

Accepted bits arrive least significant first and are shifted into a 128-bit frame register. When the lower end of that register holds the sync pattern, and the start byte equals the end byte, the block reports the frame. It gives the 64-bit data word, the 16-bit check field and a rewritable-tag flag. For rewritable tags it also compares the stored identity copy against the data and raises an error strobe on a mismatch. Any rejected group raises a symbol-error strobe and throws away the partial frame.

Top module: `fsk_frame_demod`

## Requirements
- R1: A carrier cycle is counted on each sample where `zc_in` is 1 and the previous sample was 0. The group length is the number of samples from the one after the previous group's 16th rising edge up to and including the current 16th rising edge.
- R2: A group length strictly greater than 248 and strictly less than 270 yields bit value 1. This window is tested first.
- R3: A group length strictly greater than 227 and strictly less than 249 yields bit value 0, provided the length is not already in the R2 window.
- R4: A group length in neither window pulses `sym_err` for one cycle and clears the entire frame register, so a frame interrupted by such a group is never reported.
- R5: The sample counter saturates at its maximum value (1023 with default parameters). A very long group therefore cannot wrap into a valid window.
- R6: Each accepted bit enters frame register bit 127 while the register shifts right. On acceptance, `frm_data` = bits [87:24] and `frm_chk` = bits [103:88].
- R7: A frame is accepted only when bits [22:0] equal 0x7E0000 (bits 22..17 set, bits 16..0 clear) and bits [23:16] equal bits [111:104]. Otherwise no `frm_valid` pulse occurs.
- R8: `frm_rw` equals frame register bit 111 of the accepted frame.
- R9: When `frm_rw` is 1, `frm_id_err` pulses together with `frm_valid` if bits [126:112] differ from data bits [14:0]. Bit 127 and data bit 15 take no part in the comparison. For a read-only frame `frm_id_err` stays 0.
- R10: Each accepted frame gives exactly one `frm_valid` pulse. The register is then cleared, and the output fields hold until the next accepted frame.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample strobe; `zc_in` is taken when high |
| zc_in | input | 1 | Zero-crossing comparator output |
| frm_valid | output | 1 | One-cycle pulse: frame accepted |
| frm_data | output | 64 | Data word of last accepted frame |
| frm_chk | output | 16 | Check field of last accepted frame |
| frm_rw | output | 1 | Last accepted frame came from a rewritable tag |
| frm_id_err | output | 1 | Pulse with `frm_valid`: identity copy mismatch |
| sym_err | output | 1 | One-cycle pulse: group length outside both windows |

## Verification
Frame acceptance and the identity comparison resolve on the same register state, so `frm_valid` and `frm_id_err` must rise in the same cycle. This is provoked by a rewritable frame whose identity copy differs from the data in one bit. A monitor samples both strobes on the same falling edge and checks that the error appears only together with the valid pulse, never a cycle late. A second collision is a rejected group arriving one bit before a complete frame. Here the clear has to win, and the bench judges this by the absence of any valid pulse.

// File: rtl/fskd_pkg.sv
// Package: shared constants and the frame result type for the demodulator.
// Assumes the fixed 128-bit frame layout used by the frame register.
package fskd_pkg;
    localparam int          FRAME_W  = 128;
    localparam logic [22:0] SYNC_VAL = 23'h7E0000;

    typedef struct packed {
        logic [63:0] data;
        logic [15:0] chk;
        logic        rw;
    } fskd_frame_t;
endpackage

// File: rtl/fskd_cycle_timer.sv
// Module: counts rising edges of the sampled zero-crossing input and, after
// every CYC_N edges, emits the number of samples the group spanned.
// Assumes one sample per smp_vld strobe; the sample counter saturates.
module fskd_cycle_timer #(
    parameter int CNT_W = 10,
    parameter int CYC_N = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic             zc_in,
    output logic             grp_vld,
    output logic [CNT_W-1:0] grp_len
);
    localparam int               CYC_W   = $clog2(CYC_N);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             zc_q;
    logic [CYC_W-1:0] cyc_cnt;
    logic [CNT_W-1:0] smp_cnt;
    logic             rise;
    logic             last;
    logic [CNT_W-1:0] cnt_inc;

    // Edge detect, group end and saturating increment.
    always_comb begin
        rise    = smp_vld && zc_in && !zc_q;
        last    = rise && (cyc_cnt == CYC_W'(CYC_N - 1));
        cnt_inc = (smp_cnt == CNT_MAX) ? smp_cnt : smp_cnt + 1'b1;
    end

    // Sample/cycle counters and the group result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zc_q    <= 1'b0;
            cyc_cnt <= '0;
            smp_cnt <= '0;
            grp_vld <= 1'b0;
            grp_len <= '0;
        end else begin
            grp_vld <= 1'b0;
            if (smp_vld) begin
                zc_q <= zc_in;
                if (last) begin
                    grp_vld <= 1'b1;
                    grp_len <= cnt_inc;
                    smp_cnt <= '0;
                    cyc_cnt <= '0;
                end else begin
                    smp_cnt <= cnt_inc;
                    if (rise) cyc_cnt <= cyc_cnt + 1'b1;
                end
            end
        end
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && smp_cnt == CNT_MAX && !last) |=> (smp_cnt == CNT_MAX)); // R5

    AST_GROUP_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        grp_vld |-> (grp_len >= CNT_W'(CYC_N))); // R1
endmodule

// File: rtl/fskd_bit_slicer.sv
// Module: maps a group length to a bit value using two tolerance windows,
// the logic-1 window taking priority; flags lengths outside both.
// Assumes NOM_ONE > NOM_ZERO and the windows fit in CNT_W bits.
module fskd_bit_slicer #(
    parameter int CNT_W    = 10,
    parameter int NOM_ONE  = 259,
    parameter int NOM_ZERO = 238,
    parameter int TOL      = 11
) (
    input  logic             grp_vld,
    input  logic [CNT_W-1:0] grp_len,
    output logic             bit_vld,
    output logic             bit_val,
    output logic             bit_bad
);
    localparam logic [CNT_W-1:0] ONE_LO  = CNT_W'(NOM_ONE - TOL);
    localparam logic [CNT_W-1:0] ONE_HI  = CNT_W'(NOM_ONE + TOL);
    localparam logic [CNT_W-1:0] ZERO_LO = CNT_W'(NOM_ZERO - TOL);
    localparam logic [CNT_W-1:0] ZERO_HI = CNT_W'(NOM_ZERO + TOL);

    logic in_one;
    logic in_zero;

    // Window tests with the logic-1 window checked first.
    always_comb begin
        in_one  = (grp_len > ONE_LO) && (grp_len < ONE_HI);
        in_zero = !in_one && (grp_len > ZERO_LO) && (grp_len < ZERO_HI);
        bit_vld = grp_vld && (in_one || in_zero);
        bit_val = in_one;
        bit_bad = grp_vld && !in_one && !in_zero;
    end
endmodule

// File: rtl/fskd_frame_reg.sv
// Module: 128-bit right-shifting frame register with sync/byte match,
// field extraction, identity check and clear-on-report.
// Assumes bit_vld and bit_bad are never high together.
module fskd_frame_reg
    import fskd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_vld,
    input  logic        bit_val,
    input  logic        bit_bad,
    output logic        frm_valid,
    output fskd_frame_t frm,
    output logic        id_err,
    output logic        sym_err
);
    logic [FRAME_W-1:0] shreg;
    logic               sync_hit;
    logic               bytes_eq;
    logic               accept;
    logic               id_diff;

    // Candidate detection on the current register contents.
    always_comb begin
        sync_hit = (shreg[22:0] == SYNC_VAL);
        bytes_eq = (shreg[23:16] == shreg[111:104]);
        accept   = sync_hit && bytes_eq;
        id_diff  = (shreg[126:112] != shreg[38:24]);
    end

    // Shift, clear and report registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            frm_valid <= 1'b0;
            frm       <= '0;
            id_err    <= 1'b0;
            sym_err   <= 1'b0;
        end else begin
            frm_valid <= accept;
            id_err    <= accept && shreg[111] && id_diff;
            sym_err   <= bit_bad;
            if (accept) begin
                frm.data <= shreg[87:24];
                frm.chk  <= shreg[103:88];
                frm.rw   <= shreg[111];
            end
            if (accept || bit_bad) begin
                shreg <= '0;
            end else if (bit_vld) begin
                shreg <= {bit_val, shreg[FRAME_W-1:1]};
            end
        end
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> !frm_valid); // R10

    AST_BAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        bit_bad |=> (shreg == '0)); // R4

    AST_IDERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        id_err |-> (frm_valid && frm.rw)); // R9

    AST_SHIFT_IN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !accept) |=> (shreg[FRAME_W-1] == $past(bit_val))); // R6
endmodule

// File: rtl/fsk_frame_demod.sv
// Module: top of the FSK zero-crossing frame demodulator. Chains the cycle
// timer, the bit slicer and the frame register.
// Assumes zc_in is already synchronous to clk.
module fsk_frame_demod
    import fskd_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int CYC_N    = 16,
    parameter int NOM_ONE  = 259,
    parameter int NOM_ZERO = 238,
    parameter int TOL      = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_vld,
    input  logic        zc_in,
    output logic        frm_valid,
    output logic [63:0] frm_data,
    output logic [15:0] frm_chk,
    output logic        frm_rw,
    output logic        frm_id_err,
    output logic        sym_err
);
    logic             grp_vld;
    logic [CNT_W-1:0] grp_len;
    logic             bit_vld;
    logic             bit_val;
    logic             bit_bad;
    fskd_frame_t      frm;

    fskd_cycle_timer #(.CNT_W(CNT_W), .CYC_N(CYC_N)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .zc_in   (zc_in),
        .grp_vld (grp_vld),
        .grp_len (grp_len)
    );

    fskd_bit_slicer #(
        .CNT_W(CNT_W), .NOM_ONE(NOM_ONE), .NOM_ZERO(NOM_ZERO), .TOL(TOL)
    ) u_slicer (
        .grp_vld (grp_vld),
        .grp_len (grp_len),
        .bit_vld (bit_vld),
        .bit_val (bit_val),
        .bit_bad (bit_bad)
    );

    fskd_frame_reg u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (bit_vld),
        .bit_val   (bit_val),
        .bit_bad   (bit_bad),
        .frm_valid (frm_valid),
        .frm       (frm),
        .id_err    (frm_id_err),
        .sym_err   (sym_err)
    );

    // Unpack the held frame fields onto the ports.
    always_comb begin
        frm_data = frm.data;
        frm_chk  = frm.chk;
        frm_rw   = frm.rw;
    end
endmodule

// File: tb/fsk_frame_demod_test.sv
module fsk_frame_demod_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic        zc_in = 1'b0;
    logic        frm_valid;
    logic [63:0] frm_data;
    logic [15:0] frm_chk;
    logic        frm_rw;
    logic        frm_id_err;
    logic        sym_err;

    int          checks = 0;
    int          fails = 0;
    int          vcnt = 0;
    int          ecnt = 0;
    int          pend = 0;
    bit          done = 1'b0;
    logic [63:0] cap_data = '0;
    logic [15:0] cap_chk = '0;
    logic        cap_rw = 1'b0;
    logic        cap_id = 1'b0;

    always #10 clk = ~clk;

    fsk_frame_demod uut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .zc_in(zc_in),
        .frm_valid(frm_valid), .frm_data(frm_data), .frm_chk(frm_chk),
        .frm_rw(frm_rw), .frm_id_err(frm_id_err), .sym_err(sym_err)
    );

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && frm_valid) begin
            vcnt++;
            cap_data = frm_data;
            cap_chk  = frm_chk;
            cap_rw   = frm_rw;
            cap_id   = frm_id_err;
        end
        if (rst_n && sym_err) ecnt++;
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(logic v);
        @(negedge clk);
        zc_in = v;
        pend++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) put(1'b0);
    endtask

    // One group of 16 rising edges spanning exactly len samples.
    task automatic send_group(int len);
        int eff = len - pend;
        int base = eff / 16;
        pend = 0;
        for (int c = 0; c < 16; c++) begin
            int p = (c == 15) ? eff - 15 * base : base;
            for (int k = 0; k < p - 1; k++) begin
                @(negedge clk);
                zc_in = 1'b0;
            end
            @(negedge clk);
            zc_in = 1'b1;
        end
    endtask

    function automatic int bit_len(logic b, int i, bit bnd);
        if (!bnd) return b ? 259 : 238;
        case (i % 3)
            0: return b ? 259 : 238;
            1: return b ? 249 : 228;
            default: return b ? 269 : 248;
        endcase
    endfunction

    function automatic logic [127:0] make_frame(logic [7:0] sb, logic [7:0] eb,
            logic [63:0] data, logic [15:0] chk, logic [14:0] ident, logic top);
        logic [127:0] f = '0;
        f[23:16]   = sb;
        f[87:24]   = data;
        f[103:88]  = chk;
        f[111:104] = eb;
        f[126:112] = ident;
        f[127]     = top;
        return f;
    endfunction

    // Flush with a rejected group, then send all bits, optionally cut by a bad group.
    task automatic send_frame(logic [127:0] f, bit bnd, int cut);
        send_group(100);
        for (int i = 0; i < 128; i++) begin
            if (i == cut) send_group(227);
            send_group(bit_len(f[i], i, bnd));
        end
        idle(6);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R11 valid", 64'(frm_valid), 0);
        check("R11 data", frm_data, 0);
        check("R11 chk/rw/err", {frm_chk, frm_rw, frm_id_err, sym_err}, 0);
        rst_n = 1'b1;
        smp_vld = 1'b1;
        pend = 0;
    endtask

    task automatic t_windows;
        int e0 = ecnt;
        send_group(270); idle(4);
        check("R4 len 270 rejected", 64'(ecnt - e0), 1);
        send_group(227); idle(4);
        check("R4 len 227 rejected", 64'(ecnt - e0), 2);
        send_group(269); idle(4);
        check("R2 len 269 accepted", 64'(ecnt - e0), 2);
        send_group(228); idle(4);
        check("R3 len 228 accepted", 64'(ecnt - e0), 2);
        send_group(249); send_group(248); idle(4);
        check("R2 R3 len 249/248 accepted", 64'(ecnt - e0), 2);
    endtask

    task automatic t_saturate;
        int e0 = ecnt;
        send_group(1283); idle(4);
        check("R5 long group saturates and is rejected", 64'(ecnt - e0), 1);
    endtask

    task automatic t_frame_ro;
        int v0 = vcnt, e0 = ecnt;
        logic [63:0] d = 64'h1234_5678_9ABC_DEF0;
        send_frame(make_frame(8'h7E, 8'h7E, d, 16'hBEEF, 15'h5A5A, 1'b1), 1'b1, -1);
        check("R10 one pulse per frame", 64'(vcnt - v0), 1);
        check("R6 data field", cap_data, d);
        check("R6 check field", 64'(cap_chk), 64'h BEEF);
        check("R8 read-only flag", 64'(cap_rw), 0);
        check("R9 no id error on read-only", 64'(cap_id), 0);
        check("R2 R3 boundary lengths no sym_err", 64'(ecnt - e0), 1);
        check("R10 fields held", frm_data, d);
    endtask

    task automatic t_frame_rw_ok;
        int v0 = vcnt;
        logic [63:0] d = 64'h0F1E_2D3C_4B5A_6978;
        send_frame(make_frame(8'hFE, 8'hFE, d, 16'h1357, d[14:0], 1'b1), 1'b0, -1);
        check("R10 one pulse rw frame", 64'(vcnt - v0), 1);
        check("R6 rw data", cap_data, d);
        check("R8 rewritable flag", 64'(cap_rw), 1);
        check("R9 matching ident, bit 127 ignored", 64'(cap_id), 0);
    endtask

    task automatic t_frame_rw_bad;
        int v0 = vcnt;
        logic [63:0] d = 64'hCAFE_F00D_0000_8001;
        send_frame(make_frame(8'hFE, 8'hFE, d, 16'h0042, 15'h0000, 1'b0), 1'b0, -1);
        check("R10 one pulse mismatch frame", 64'(vcnt - v0), 1);
        check("R9 ident mismatch flagged with valid", 64'(cap_id), 1);
        check("R6 chk of mismatch frame", 64'(cap_chk), 64'h0042);
    endtask

    task automatic t_byte_mismatch;
        int v0 = vcnt;
        send_frame(make_frame(8'h7E, 8'h7F, 64'h55AA_55AA_0123_4567, 16'h0, 15'h0, 1'b0),
                   1'b0, -1);
        check("R7 start/end byte mismatch not reported", 64'(vcnt - v0), 0);
    endtask

    task automatic t_cut_frame;
        int v0 = vcnt, e0 = ecnt;
        send_frame(make_frame(8'h7E, 8'h7E, 64'h0BAD_F00D_1111_2222, 16'h7777, 15'h1, 1'b0),
                   1'b0, 127);
        check("R4 bad group clears partial frame", 64'(vcnt - v0), 0);
        check("R4 two rejected groups", 64'(ecnt - e0), 2);
    endtask

    initial begin
        t_reset();
        t_windows();
        t_saturate();
        t_frame_ro();
        t_frame_rw_ok();
        t_frame_rw_bad();
        t_byte_mismatch();
        t_cut_frame();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule